// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the general-purpose integer registers of a processor core. The registers are split into a small group of globals and a ring of overlapping register windows. An instruction sees 32 logical registers: 8 globals, 8 outs, 8 locals and 8 ins. A current window pointer selects which physical window backs the out, local and in registers. The outs of the active window are the same physical storage as the ins of the next window down the ring. A procedure call can therefore hand arguments over without copying them.

A save request moves the pointer one window down and a restore request moves it one window up, with wraparound at the ends of the ring. An invalid-window mask marks windows that must not be entered. When a save or restore would land on a marked window, the block raises an overflow or underflow flag and leaves the pointer where it is. Trap entry always steps the pointer down. In the same cycle it stores the trapped program counter and next program counter into two locals of the window it enters. A control port lets software load the pointer and the mask directly.

Top module: `wreg_file`

## Requirements
- R1: After reset the window pointer is 0, the invalid-window mask is all zeros, and both trap flags are low.
- R2: Logical register 0 always reads as zero on both read ports. A write to it has no effect.
- R3: Logical registers 0 to 7 are globals. They map to the same storage whatever the window pointer is.
- R4: A save with the target window unmasked decrements the pointer at the next clock edge. A value in out register 8+k before the save reads back as in register 24+k after it.
- R5: A restore with the target window unmasked increments the pointer. A value in in register 24+k before the restore reads back as out register 8+k after it.
- R6: Locals (logical registers 16 to 23) are private to each window. Writing a local in one window does not change that local in any other window.
- R7: A save whose target window (pointer minus 1, modulo the window count) has its mask bit set drives `ovf_o` high in that same cycle. The pointer stays unchanged.
- R8: A restore whose target window (pointer plus 1, modulo the window count) has its mask bit set drives `unf_o` high in that same cycle. The pointer stays unchanged.
- R9: Trap entry decrements the pointer even when the mask bit of the target window is set. The trap PC goes to logical register 17 of the new window and the trap nPC goes to logical register 18 of the new window.
- R10: Reads are combinational. A read of the register being written in the same cycle returns the new data.
- R11: A control write loads the pointer with the supplied value modulo the window count and loads the mask. It takes priority over trap, save and restore. Trap beats save, and save beats restore.
- R12: The pointer wraps: a save at window 0 goes to the last window, and a restore at the last window goes to window 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rs1_addr_i | input | 5 | Read port A logical register |
| rs1_data_o | output | XLEN | Read port A data |
| rs2_addr_i | input | 5 | Read port B logical register |
| rs2_data_o | output | XLEN | Read port B data |
| rd_we_i | input | 1 | Write enable |
| rd_addr_i | input | 5 | Write logical register |
| rd_data_i | input | XLEN | Write data |
| save_i | input | 1 | Save request (enter next window) |
| restore_i | input | 1 | Restore request (return to previous window) |
| trap_i | input | 1 | Trap entry request |
| trap_pc_i | input | XLEN | Trapped PC to store |
| trap_npc_i | input | XLEN | Trapped next PC to store |
| ctl_we_i | input | 1 | Load pointer and mask |
| ctl_cwp_i | input | 5 | Pointer value to load |
| ctl_wim_i | input | NWIN | Mask value to load |
| cwp_o | output | 5 | Current window pointer |
| wim_o | output | NWIN | Invalid-window mask |
| ovf_o | output | 1 | Save blocked by mask |
| unf_o | output | 1 | Restore blocked by mask |

## Verification
The hardest cases to reach are the mask-blocked rotations and the unconditional trap step. They only happen when a specific mask bit sits next to a specific pointer value, and that pair takes many saves to reach from reset. The bench instead uses the control port to place the pointer and the mask next to each other in one cycle. It then issues the save, restore or trap. The overlap and wrap cases are driven by writing an out or in register just before rotating through window 0 and the last window, then reading the value back under its other logical name.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int NGLOB    = 8;
  localparam int WIN_REGS = 16;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CTL,
    OP_TRAP,
    OP_SAVE,
    OP_RESTORE
  } win_op_e;

  function automatic int phys_index(input int win, input int off);
    return NGLOB + WIN_REGS * win + off;
  endfunction
endpackage

// File: rtl/wrf_window_ctl.sv
module wrf_window_ctl #(
  parameter int NWIN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic            trap_i,
  input  logic            ctl_we_i,
  input  logic [4:0]      ctl_cwp_i,
  input  logic [NWIN-1:0] ctl_wim_i,
  output logic [4:0]      cwp_o,
  output logic [4:0]      cwp_dn_o,
  output logic [NWIN-1:0] wim_o,
  output logic            ovf_o,
  output logic            unf_o,
  output logic            trap_wr_o
);
  import wrf_pkg::*;

  localparam logic [4:0] LAST = 5'(NWIN - 1);

  logic [4:0]      cwp_q, cwp_d, cwp_dn, cwp_up;
  logic [NWIN-1:0] wim_q, wim_d, wim_dn_sh, wim_up_sh;
  win_op_e         op;

  assign cwp_dn    = (cwp_q == 5'd0) ? LAST : cwp_q - 5'd1;
  assign cwp_up    = (cwp_q == LAST) ? 5'd0 : cwp_q + 5'd1;
  assign wim_dn_sh = wim_q >> cwp_dn;
  assign wim_up_sh = wim_q >> cwp_up;

  // priority: control > trap > save > restore
  always_comb begin
    if (ctl_we_i)       op = OP_CTL;
    else if (trap_i)    op = OP_TRAP;
    else if (save_i)    op = OP_SAVE;
    else if (restore_i) op = OP_RESTORE;
    else                op = OP_NONE;
  end

  assign ovf_o     = (op == OP_SAVE)    && wim_dn_sh[0];
  assign unf_o     = (op == OP_RESTORE) && wim_up_sh[0];
  assign trap_wr_o = (op == OP_TRAP);

  always_comb begin
    cwp_d = cwp_q;
    wim_d = wim_q;
    unique case (op)
      OP_CTL: begin
        cwp_d = 5'(ctl_cwp_i % NWIN);
        wim_d = ctl_wim_i;
      end
      OP_TRAP:    cwp_d = cwp_dn;
      OP_SAVE:    if (!wim_dn_sh[0]) cwp_d = cwp_dn;
      OP_RESTORE: if (!wim_up_sh[0]) cwp_d = cwp_up;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= '0;
      wim_q <= '0;
    end else begin
      cwp_q <= cwp_d;
      wim_q <= wim_d;
    end
  end

  assign cwp_o    = cwp_q;
  assign cwp_dn_o = cwp_dn;
  assign wim_o    = wim_q;

  a_r7_ovf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> $stable(cwp_o));
  a_r8_unf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> $stable(cwp_o));
  a_r4_save_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !ctl_we_i && !trap_i && !ovf_o) |=>
      cwp_o == (($past(cwp_o) == 5'd0) ? LAST : $past(cwp_o) - 5'd1));
  a_r9_trap_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && !ctl_we_i) |=>
      cwp_o == (($past(cwp_o) == 5'd0) ? LAST : $past(cwp_o) - 5'd1));
  a_r12_cwp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cwp_o <= LAST);
  a_r11_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && unf_o));
endmodule

// File: rtl/wrf_map.sv
module wrf_map #(
  parameter int NWIN = 8,
  parameter int PW   = 8
) (
  input  logic [4:0]    cwp_i,
  input  logic [4:0]    cwp_dn_i,
  input  logic [4:0]    laddr_i,
  output logic [PW-1:0] phys_o
);
  import wrf_pkg::*;

  logic [2:0] off;
  assign off = laddr_i[2:0];

  always_comb begin
    unique case (laddr_i[4:3])
      2'd0: phys_o = PW'(off);
      2'd1: phys_o = PW'(phys_index(int'(cwp_dn_i), int'(off)));      // outs = ins below
      2'd2: phys_o = PW'(phys_index(int'(cwp_i), 8 + int'(off)));     // locals
      default: phys_o = PW'(phys_index(int'(cwp_i), int'(off)));      // ins
    endcase
  end
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int XLEN  = 32,
  parameter int NPHYS = 136,
  parameter int PW    = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PW-1:0]   ra_i   [2],
  output logic [XLEN-1:0] rdata_o[2],
  input  logic            we_i,
  input  logic [PW-1:0]   wa_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            twe_i,
  input  logic [PW-1:0]   twa_i  [2],
  input  logic [XLEN-1:0] twdata_i[2]
);
  logic [XLEN-1:0] mem [NPHYS];

  always_ff @(posedge clk_i) begin
    if (we_i && wa_i != '0) mem[wa_i] <= wdata_i;
    if (twe_i) begin
      mem[twa_i[0]] <= twdata_i[0];
      mem[twa_i[1]] <= twdata_i[1];
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_comb begin
      if (ra_i[p] == '0)                     rdata_o[p] = '0;
      else if (we_i && wa_i == ra_i[p])      rdata_o[p] = wdata_i;  // write-first
      else                                   rdata_o[p] = mem[ra_i[p]];
    end

    a_r2_zero_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ra_i[p] == '0) |-> (rdata_o[p] == '0));
  end
endmodule

// File: rtl/wreg_file.sv
module wreg_file #(
  parameter int NWIN = 8,
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [4:0]      rs1_addr_i,
  output logic [XLEN-1:0] rs1_data_o,
  input  logic [4:0]      rs2_addr_i,
  output logic [XLEN-1:0] rs2_data_o,
  input  logic            rd_we_i,
  input  logic [4:0]      rd_addr_i,
  input  logic [XLEN-1:0] rd_data_i,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic            trap_i,
  input  logic [XLEN-1:0] trap_pc_i,
  input  logic [XLEN-1:0] trap_npc_i,
  input  logic            ctl_we_i,
  input  logic [4:0]      ctl_cwp_i,
  input  logic [NWIN-1:0] ctl_wim_i,
  output logic [4:0]      cwp_o,
  output logic [NWIN-1:0] wim_o,
  output logic            ovf_o,
  output logic            unf_o
);
  import wrf_pkg::*;

  localparam int NPHYS = NGLOB + WIN_REGS * NWIN;
  localparam int PW    = $clog2(NPHYS);

  logic [4:0]      cwp, cwp_dn;
  logic            trap_wr;
  logic [4:0]      rd_laddr[2];
  logic [PW-1:0]   ra[2], twa[2], wa;
  logic [XLEN-1:0] rdata[2], twdata[2];

  wrf_window_ctl #(.NWIN(NWIN)) u_ctl (
    .clk_i, .rst_ni, .save_i, .restore_i, .trap_i, .ctl_we_i, .ctl_cwp_i, .ctl_wim_i,
    .cwp_o(cwp), .cwp_dn_o(cwp_dn), .wim_o, .ovf_o, .unf_o, .trap_wr_o(trap_wr)
  );

  assign rd_laddr[0] = rs1_addr_i;
  assign rd_laddr[1] = rs2_addr_i;

  for (genvar p = 0; p < 2; p++) begin : g_rmap
    wrf_map #(.NWIN(NWIN), .PW(PW)) u_map (
      .cwp_i(cwp), .cwp_dn_i(cwp_dn), .laddr_i(rd_laddr[p]), .phys_o(ra[p])
    );
  end

  wrf_map #(.NWIN(NWIN), .PW(PW)) u_wmap (
    .cwp_i(cwp), .cwp_dn_i(cwp_dn), .laddr_i(rd_addr_i), .phys_o(wa)
  );

  // trap PC -> local 1, nPC -> local 2 of the entered window
  for (genvar t = 0; t < 2; t++) begin : g_tmap
    wrf_map #(.NWIN(NWIN), .PW(PW)) u_tmap (
      .cwp_i(cwp_dn), .cwp_dn_i(cwp_dn), .laddr_i(5'(17 + t)), .phys_o(twa[t])
    );
  end

  assign twdata[0] = trap_pc_i;
  assign twdata[1] = trap_npc_i;

  wrf_storage #(.XLEN(XLEN), .NPHYS(NPHYS), .PW(PW)) u_store (
    .clk_i, .rst_ni, .ra_i(ra), .rdata_o(rdata),
    .we_i(rd_we_i), .wa_i(wa), .wdata_i(rd_data_i),
    .twe_i(trap_wr), .twa_i(twa), .twdata_i(twdata)
  );

  assign rs1_data_o = rdata[0];
  assign rs2_data_o = rdata[1];
  assign cwp_o      = cwp;

  a_r10_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_we_i && rd_addr_i != 5'd0 && rd_addr_i == rs1_addr_i) |-> rs1_data_o == rd_data_i);
  a_r3_global_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs1_addr_i[4:3] == 2'd0) |-> (ra[0] == PW'(rs1_addr_i)));
endmodule

// File: tb/tb_wreg_file.sv
`timescale 1ns/1ps
module tb_wreg_file;
  localparam int NWIN = 8;
  localparam int XLEN = 32;

  logic            clk_i = 1'b0, rst_ni = 1'b0;
  logic [4:0]      rs1_addr_i = '0, rs2_addr_i = '0, rd_addr_i = '0, ctl_cwp_i = '0;
  logic [XLEN-1:0] rs1_data_o, rs2_data_o, rd_data_i = '0, trap_pc_i = '0, trap_npc_i = '0;
  logic            rd_we_i = 0, save_i = 0, restore_i = 0, trap_i = 0, ctl_we_i = 0;
  logic [NWIN-1:0] ctl_wim_i = '0, wim_o;
  logic [4:0]      cwp_o;
  logic            ovf_o, unf_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  wreg_file #(.NWIN(NWIN), .XLEN(XLEN)) dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #2;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    rd_we_i = 1; rd_addr_i = a; rd_data_i = d;
    step();
    rd_we_i = 0;
  endtask

  task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
    rs1_addr_i = a; rs2_addr_i = a; #1;
    chk(req, rs1_data_o, exp);
    chk(req, rs2_data_o, exp);
  endtask

  task automatic ctl(input logic [4:0] c, input logic [NWIN-1:0] m);
    ctl_we_i = 1; ctl_cwp_i = c; ctl_wim_i = m;
    step();
    ctl_we_i = 0;
  endtask

  task automatic do_save();    save_i = 1;    step(); save_i = 0;    endtask
  task automatic do_restore(); restore_i = 1; step(); restore_i = 0; endtask

  task automatic t_reset();
    chk("R1 cwp", 32'(cwp_o), 0);
    chk("R1 wim", 32'(wim_o), 0);
    chk("R1 flags", {30'd0, ovf_o, unf_o}, 0);
  endtask

  task automatic t_r0();
    wr(5'd0, 32'hDEAD_0000);
    rd("R2 r0", 5'd0, 0);
  endtask

  task automatic t_globals_overlap_wrap();
    wr(5'd3, 32'hA0A0_0003);
    wr(5'd8, 32'hB0B0_0008);
    wr(5'd15, 32'hB0B0_000F);
    do_save();
    chk("R12 save wrap", 32'(cwp_o), NWIN - 1);
    rd("R3 global", 5'd3, 32'hA0A0_0003);
    rd("R4 out->in", 5'd24, 32'hB0B0_0008);
    rd("R4 out->in", 5'd31, 32'hB0B0_000F);
    wr(5'd25, 32'hC0C0_0019);
    do_restore();
    chk("R12 restore wrap", 32'(cwp_o), 0);
    rd("R5 in->out", 5'd9, 32'hC0C0_0019);
  endtask

  task automatic t_locals();
    wr(5'd16, 32'hD000_0010);
    do_save();
    wr(5'd16, 32'hE000_0010);
    rd("R6 local new", 5'd16, 32'hE000_0010);
    do_restore();
    rd("R6 local old", 5'd16, 32'hD000_0010);
  endtask

  task automatic t_ovf();
    ctl(5'd0, 8'h80);
    save_i = 1; #1;
    chk("R7 ovf", 32'(ovf_o), 1);
    chk("R7 no unf", 32'(unf_o), 0);
    step(); save_i = 0;
    chk("R7 cwp held", 32'(cwp_o), 0);
  endtask

  task automatic t_unf();
    ctl(5'd3, 8'h10);
    restore_i = 1; #1;
    chk("R8 unf", 32'(unf_o), 1);
    step(); restore_i = 0;
    chk("R8 cwp held", 32'(cwp_o), 3);
    ctl(5'd3, 8'h00);
    do_restore();
    chk("R5 restore inc", 32'(cwp_o), 4);
  endtask

  task automatic t_trap();
    ctl(5'd2, 8'h02);
    trap_i = 1; trap_pc_i = 32'h0000_4000; trap_npc_i = 32'h0000_4004;
    step(); trap_i = 0;
    chk("R9 trap cwp", 32'(cwp_o), 1);
    rd("R9 pc", 5'd17, 32'h0000_4000);
    rd("R9 npc", 5'd18, 32'h0000_4004);
  endtask

  task automatic t_bypass();
    rd_we_i = 1; rd_addr_i = 5'd20; rd_data_i = 32'hF00D_0014;
    rs1_addr_i = 5'd20; rs2_addr_i = 5'd20; #1;
    chk("R10 bypass a", rs1_data_o, 32'hF00D_0014);
    chk("R10 bypass b", rs2_data_o, 32'hF00D_0014);
    step(); rd_we_i = 0;
    rd("R10 stored", 5'd20, 32'hF00D_0014);
  endtask

  task automatic t_priority();
    ctl_we_i = 1; ctl_cwp_i = 5'd13; ctl_wim_i = 8'h00; save_i = 1; trap_i = 1;
    step();
    ctl_we_i = 0; trap_i = 0;
    chk("R11 ctl mod", 32'(cwp_o), 5);
    restore_i = 1;
    step(); save_i = 0; restore_i = 0;
    chk("R11 save over restore", 32'(cwp_o), 4);
  endtask

  initial begin
    #5; t_reset();
    #20 rst_ni = 1'b1;
    step();
    t_reset();
    t_r0();
    t_globals_overlap_wrap();
    t_locals();
    t_ovf();
    t_unf();
    t_trap();
    t_bypass();
    t_priority();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule